// File: doc/BRIEF.md
# Programmed-I/O Parallel Port FIFO with Threshold Interrupt

This block is the byte queue that sits between a host register interface and the peripheral side of an extended-capabilities parallel port. It is serviced by programmed I/O. When the port sends data out (forward), the host writes bytes into the queue. Each byte is tagged as ordinary data or as a command/address byte, and the peripheral side drains them in order. When the port receives data (reverse), the peripheral side fills the queue and the host reads the bytes out.

The block tracks queue occupancy and compares it against a 4-bit threshold to raise a service interrupt. In the reverse direction the test asks whether enough bytes are waiting to be read. In the forward direction it asks whether enough room is free to be written. The interrupt is masked whenever the service mask bit or the DMA enable bit is set. A DMA request output covers the DMA use of the same queue, and a terminal-count pulse sets the service mask so that the request drops.

Full, empty and a level counter can all be read, so the host can size each burst. Accesses that would overflow or underflow the queue are dropped and recorded in a sticky error flag.

Top module: `ecp_pio_fifo`

## Requirements
- R1: The queue holds 16 entries in first-in first-out order. The level register (read at host address 4) gives the occupancy, 0 to 16. The status register (host address 3) has bit 0 = empty and bit 1 = full.
- R2: In the forward direction, a host write to address 0 enqueues a data byte with tag 0, and a write to address 1 enqueues a byte with tag 1. A `p_pop` on a non-empty queue makes `p_valid` high in the following cycle, with `p_data` and `p_addr_tag` showing the oldest entry.
- R3: In the reverse direction, `p_push` enqueues `p_wdata`. A host read of address 0 dequeues the oldest byte, which appears on `h_rdata` in the cycle after the read.
- R4: The effective threshold equals the 4-bit field, except that field value 0 stands for 16 and is treated as 15.
- R5: In the reverse direction, with the interrupt unmasked, `svc_irq` is high when the level is at least 16 minus the effective threshold. It follows the level with one cycle of delay.
- R6: In the forward direction, with the interrupt unmasked, `svc_irq` is high when the level is at most the effective threshold.
- R7: `svc_irq` stays low while the service mask bit or the DMA enable bit is 1. Status bit 3 mirrors `svc_irq`.
- R8: A push into a full queue or a pop from an empty queue leaves the queue unchanged and sets the sticky error flag (status bit 2). A host read that is dropped this way returns 0. Writing status with bit 2 = 1 clears the flag.
- R9: Accesses against the selected direction are ignored and do not set the error flag. This covers host FIFO writes in reverse, peripheral pushes in forward, host data reads in forward and peripheral pops in reverse.
- R10: `dma_req` (status bit 4) is high when DMA is enabled and the service mask is 0, and also either the level is at least 1 (reverse) or the queue is not full (forward). A `dma_tc` pulse sets the service mask to 1.
- R11: After reset the level is 0, status reads 0x01, configuration reads 0x40, and `svc_irq`, `dma_req` and `p_valid` are low.
- R12: The configuration register (host address 2) holds the threshold in bits 3:0, the direction in bit 4 (1 = reverse), DMA enable in bit 5 and the service mask in bit 6. Bit 7 reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 3 | Host register select: 0 data, 1 tagged byte, 2 config, 3 status, 4 level |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, valid the cycle after `h_rd` |
| p_push | input | 1 | Peripheral enqueue strobe (reverse) |
| p_wdata | input | 8 | Peripheral byte to enqueue |
| p_pop | input | 1 | Peripheral dequeue strobe (forward) |
| p_valid | output | 1 | Dequeued byte present on `p_data` |
| p_data | output | 8 | Dequeued byte |
| p_addr_tag | output | 1 | Tag of the dequeued byte |
| dma_tc | input | 1 | DMA terminal-count pulse |
| svc_irq | output | 1 | Service interrupt |
| dma_req | output | 1 | DMA request |

## Verification
The hardest conditions to reach are the ends of the threshold comparison: field 0 standing for 15, and the exact level on each side of each cut-off in both directions. These need the queue parked at a chosen occupancy after a clean reset. A vector table walks pairs of threshold and level on either side of every edge, filling the queue from the side that owns the chosen direction. A second awkward case is a pop arriving just as an overflow attempt has been made. Directed tests handle it by draining the whole queue after the 17th write and checking that the last byte is still the 16th one written.

// File: rtl/ppf_pkg.sv
package ppf_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SEL_DATA  = 3'd0,
    SEL_TAGGED = 3'd1,
    SEL_CFG   = 3'd2,
    SEL_STAT  = 3'd3,
    SEL_LVL   = 3'd4
  } host_sel_e;

  // status bit positions
  localparam int ST_EMPTY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_ERR   = 2;
  localparam int ST_IRQ   = 3;
  localparam int ST_DREQ  = 4;

  // configuration bit positions (threshold sits in the low bits)
  localparam int CF_DIR  = 4;
  localparam int CF_DMA  = 5;
  localparam int CF_MASK = 6;
endpackage

// File: rtl/ppf_store.sv
module ppf_store #(
  parameter int DEPTH = 16,
  parameter int W     = 9,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  q
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/ppf_ptrs.sv
module ppf_ptrs #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          reject,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;
  assign reject  = (push_req && full) || (pop_req && empty);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= step(wptr);
      if (pop_ok)  rptr <= step(rptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  a_r1_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (full && push_req && !pop_req) |=> full);
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (empty && pop_req && !push_req) |=> empty);
endmodule

// File: rtl/ppf_irq.sv
module ppf_irq #(
  parameter int DEPTH = 16,
  localparam int TW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] level,
  input  logic [TW-1:0] thr,
  input  logic          dir_rev,
  input  logic          dma_en,
  input  logic          svc_mask,
  output logic          irq,
  output logic          dma_req
);
  logic [LW-1:0] eff;
  logic          rev_hit, fwd_hit, hit, dreq_c;

  // field 0 encodes DEPTH, which behaves as DEPTH-1
  assign eff     = (thr == '0) ? LW'(DEPTH - 1) : LW'(thr);
  assign rev_hit = level >= (LW'(DEPTH) - eff);
  assign fwd_hit = level <= eff;
  assign hit     = dir_rev ? rev_hit : fwd_hit;
  assign dreq_c  = dir_rev ? (level != '0) : (level != LW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      irq     <= hit && !svc_mask && !dma_en;
      dma_req <= dreq_c && dma_en && !svc_mask;
    end
  end

  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (svc_mask || dma_en) |=> !irq);
  a_r10_dma_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !dma_en |=> !dma_req);
  a_r7_irq_dma_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(irq && dma_req));
endmodule

// File: rtl/ecp_pio_fifo.sv
module ecp_pio_fifo
  import ppf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int TW   = AW,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int EW   = BYTE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [2:0]        h_addr,
  input  logic [BYTE_W-1:0] h_wdata,
  output logic [BYTE_W-1:0] h_rdata,
  input  logic              p_push,
  input  logic [BYTE_W-1:0] p_wdata,
  input  logic              p_pop,
  output logic              p_valid,
  output logic [BYTE_W-1:0] p_data,
  output logic              p_addr_tag,
  input  logic              dma_tc,
  output logic              svc_irq,
  output logic              dma_req
);
  logic [TW-1:0]     thr_q;
  logic              dir_q, dma_en_q, mask_q, err_q;
  logic              rsel_q, pvalid_q;
  logic [BYTE_W-1:0] rreg_q, reg_mux;
  logic              host_fifo_wr, host_data_rd, err_clr, cfg_wr;
  logic              push_req, pop_req, push_ok, pop_ok, reject;
  logic [AW-1:0]     wptr, rptr;
  logic [LW-1:0]     level;
  logic              full, empty;
  logic [EW-1:0]     wentry, mem_q;
  logic              unused_ok;

  assign host_fifo_wr = h_wr && (h_addr == SEL_DATA || h_addr == SEL_TAGGED);
  assign host_data_rd = h_rd && (h_addr == SEL_DATA);
  assign cfg_wr       = h_wr && (h_addr == SEL_CFG);
  assign err_clr      = h_wr && (h_addr == SEL_STAT) && h_wdata[ST_ERR];

  assign push_req = dir_q ? p_push : host_fifo_wr;
  assign pop_req  = dir_q ? host_data_rd : p_pop;
  assign wentry   = dir_q ? {1'b0, p_wdata} : {h_addr == SEL_TAGGED, h_wdata};

  ppf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .push_ok(push_ok), .pop_ok(pop_ok), .reject(reject),
    .wptr(wptr), .rptr(rptr), .level(level), .full(full), .empty(empty)
  );

  ppf_store #(.DEPTH(DEPTH), .W(EW)) u_store (
    .clk(clk), .we(push_ok), .waddr(wptr), .wdata(wentry),
    .re(pop_ok), .raddr(rptr), .q(mem_q)
  );

  ppf_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst(rst), .level(level), .thr(thr_q), .dir_rev(dir_q),
    .dma_en(dma_en_q), .svc_mask(mask_q), .irq(svc_irq), .dma_req(dma_req)
  );

  // configuration and sticky error
  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q    <= '0;
      dir_q    <= 1'b0;
      dma_en_q <= 1'b0;
      mask_q   <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      if (cfg_wr) begin
        thr_q    <= h_wdata[TW-1:0];
        dir_q    <= h_wdata[CF_DIR];
        dma_en_q <= h_wdata[CF_DMA];
        mask_q   <= h_wdata[CF_MASK];
      end
      if (dma_tc) mask_q <= 1'b1;
      if (reject)       err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  always_comb begin
    reg_mux = '0;
    case (h_addr)
      SEL_CFG: begin
        reg_mux[TW-1:0]  = thr_q;
        reg_mux[CF_DIR]  = dir_q;
        reg_mux[CF_DMA]  = dma_en_q;
        reg_mux[CF_MASK] = mask_q;
      end
      SEL_STAT: begin
        reg_mux[ST_EMPTY] = empty;
        reg_mux[ST_FULL]  = full;
        reg_mux[ST_ERR]   = err_q;
        reg_mux[ST_IRQ]   = svc_irq;
        reg_mux[ST_DREQ]  = dma_req;
      end
      SEL_LVL: reg_mux = BYTE_W'(level);
      default: reg_mux = '0;
    endcase
  end

  // host read path: register value or queue word, selected one cycle later
  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q   <= 1'b0;
      rreg_q   <= '0;
      pvalid_q <= 1'b0;
    end else begin
      if (h_rd) begin
        rsel_q <= host_data_rd && dir_q && pop_ok;
        rreg_q <= reg_mux;
      end
      pvalid_q <= !dir_q && pop_ok;
    end
  end

  assign h_rdata    = rsel_q ? mem_q[BYTE_W-1:0] : rreg_q;
  assign p_valid    = pvalid_q;
  assign p_data     = mem_q[BYTE_W-1:0];
  assign p_addr_tag = mem_q[BYTE_W];
  assign unused_ok  = ^{h_wdata[BYTE_W-1], h_wdata[3], h_wdata[1:0]};

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_q && !err_clr) |=> err_q);
  a_r8_reject_flags: assert property (@(posedge clk) disable iff (rst)
    reject |=> err_q);
  a_r10_tc_masks: assert property (@(posedge clk) disable iff (rst)
    dma_tc |=> mask_q);
  a_r2_valid_after_pop: assert property (@(posedge clk) disable iff (rst)
    (p_pop && !dir_q && !empty) |=> p_valid);
endmodule

// File: tb/tb_ecp_pio_fifo.sv
module tb_ecp_pio_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       h_wr = 0, h_rd = 0;
  logic [2:0] h_addr = '0;
  logic [7:0] h_wdata = '0, h_rdata;
  logic       p_push = 0, p_pop = 0, p_valid, p_addr_tag;
  logic [7:0] p_wdata = '0, p_data;
  logic       dma_tc = 0, svc_irq, dma_req;
  int checks = 0, fails = 0;
  logic [7:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecp_pio_fifo dut (
    .clk(clk), .rst(rst), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .p_push(p_push), .p_wdata(p_wdata),
    .p_pop(p_pop), .p_valid(p_valid), .p_data(p_data), .p_addr_tag(p_addr_tag),
    .dma_tc(dma_tc), .svc_irq(svc_irq), .dma_req(dma_req)
  );

  // {dir, thr[3:0], level[4:0], expected irq}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 4'd12, 5'd12, 1'b1}, {1'b0, 4'd12, 5'd13, 1'b0},
    {1'b0, 4'd0,  5'd15, 1'b1}, {1'b0, 4'd0,  5'd16, 1'b0},
    {1'b0, 4'd1,  5'd1,  1'b1}, {1'b0, 4'd1,  5'd2,  1'b0},
    {1'b0, 4'd15, 5'd16, 1'b0}, {1'b1, 4'd12, 5'd4,  1'b1},
    {1'b1, 4'd12, 5'd3,  1'b0}, {1'b1, 4'd0,  5'd1,  1'b1},
    {1'b1, 4'd0,  5'd0,  1'b0}, {1'b1, 4'd1,  5'd15, 1'b1},
    {1'b1, 4'd1,  5'd14, 1'b0}, {1'b1, 4'd8,  5'd8,  1'b1},
    {1'b1, 4'd8,  5'd7,  1'b0}, {1'b1, 4'd15, 5'd16, 1'b1}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; h_wr = 0; h_rd = 0; p_push = 0; p_pop = 0; dma_tc = 0;
    idle(2);
    rst = 0;
  endtask

  task automatic hw(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); h_wr = 1; h_addr = a; h_wdata = d;
    @(negedge clk); h_wr = 0;
  endtask

  task automatic hr(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); h_rd = 1; h_addr = a;
    @(negedge clk); h_rd = 0; d = h_rdata;
  endtask

  task automatic ppush(input logic [7:0] d);
    @(negedge clk); p_push = 1; p_wdata = d;
    @(negedge clk); p_push = 0;
  endtask

  task automatic ppop();
    @(negedge clk); p_pop = 1;
    @(negedge clk); p_pop = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R11 reset state
    do_reset();
    hr(3'd3, rv); chk("R11 status", rv, 8'h01);
    hr(3'd2, rv); chk("R11 config", rv, 8'h40);
    hr(3'd4, rv); chk("R11 level", rv, 8'h00);
    chk("R11 outputs", {5'b0, svc_irq, dma_req, p_valid}, 8'h00);

    // R12 config readback, bit 7 dropped
    hw(3'd2, 8'hDC); hr(3'd2, rv); chk("R12 config", rv, 8'h5C);

    // R4 R5 R6 threshold vector walk
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      hw(3'd2, {3'b000, VEC[v][10], VEC[v][9:6]});
      for (int i = 0; i < int'(VEC[v][5:1]); i++) begin
        if (VEC[v][10]) ppush(8'(i)); else hw(3'd0, 8'(i));
      end
      idle(2);
      chk($sformatf("%s%s vec%0d irq", VEC[v][10] ? "R5" : "R6",
          (VEC[v][9:6] == 0) ? " R4" : "", v), {7'b0, svc_irq}, {7'b0, VEC[v][0]});
      hr(3'd3, rv);
      chk($sformatf("R7 vec%0d status irq bit", v), {7'b0, rv[3]}, {7'b0, VEC[v][0]});
    end

    // R1 R2 forward order and tags
    do_reset();
    hw(3'd0, 8'h11); hw(3'd1, 8'h22); hw(3'd0, 8'h33);
    hr(3'd4, rv); chk("R1 level 3", rv, 8'h03);
    ppop(); chk("R2 pop1", {p_valid, p_addr_tag, 6'b0}, 8'h80); chk("R2 data1", p_data, 8'h11);
    ppop(); chk("R2 pop2 tag", {p_valid, p_addr_tag, 6'b0}, 8'hC0); chk("R2 data2", p_data, 8'h22);
    ppop(); chk("R2 data3", p_data, 8'h33);
    idle(1); chk("R2 valid drops", {7'b0, p_valid}, 8'h00);
    hr(3'd3, rv); chk("R1 empty again", rv, 8'h01);

    // R1 R8 full and overflow
    for (int i = 0; i < 16; i++) hw(3'd0, 8'(8'h40 + i));
    hr(3'd3, rv); chk("R1 full", rv, 8'h02);
    hr(3'd4, rv); chk("R1 level 16", rv, 8'h10);
    hw(3'd0, 8'hEE);
    hr(3'd3, rv); chk("R8 overflow err", rv, 8'h06);
    hr(3'd4, rv); chk("R8 level unchanged", rv, 8'h10);
    for (int i = 0; i < 16; i++) ppop();
    chk("R8 last byte intact", p_data, 8'h4F);
    hw(3'd3, 8'h04); hr(3'd3, rv); chk("R8 err cleared", rv, 8'h01);
    ppop(); chk("R8 underflow no valid", {7'b0, p_valid}, 8'h00);
    hr(3'd3, rv); chk("R8 underflow err", rv, 8'h05);

    // R3 reverse path, R8 empty read returns 0
    do_reset();
    hw(3'd2, 8'h50);
    ppush(8'hA5); ppush(8'h5A);
    hr(3'd0, rv); chk("R3 read1", rv, 8'hA5);
    hr(3'd0, rv); chk("R3 read2", rv, 8'h5A);
    hr(3'd0, rv); chk("R8 empty read zero", rv, 8'h00);
    hr(3'd3, rv); chk("R8 empty read err", rv, 8'h05);

    // R9 misdirected accesses
    hw(3'd3, 8'h04);
    ppush(8'h77);
    hw(3'd0, 8'h99); hw(3'd1, 8'h98);
    ppop(); chk("R9 no peripheral pop in reverse", {7'b0, p_valid}, 8'h00);
    hr(3'd4, rv); chk("R9 reverse level", rv, 8'h01);
    hr(3'd3, rv); chk("R9 reverse no err", rv, 8'h00);
    hr(3'd0, rv); chk("R9 reverse data", rv, 8'h77);
    do_reset();
    ppush(8'h66);
    hr(3'd0, rv); chk("R9 forward host read zero", rv, 8'h00);
    hr(3'd4, rv); chk("R9 forward level", rv, 8'h00);
    hr(3'd3, rv); chk("R9 forward no err", rv, 8'h01);

    // R7 masking
    do_reset();
    hw(3'd2, 8'h4C); idle(2); chk("R7 mask holds irq", {7'b0, svc_irq}, 8'h00);
    hw(3'd2, 8'h2C); idle(2); chk("R7 dma_en holds irq", {7'b0, svc_irq}, 8'h00);
    hw(3'd2, 8'h0C); idle(2); chk("R7 unmasked irq", {7'b0, svc_irq}, 8'h01);

    // R10 DMA request and terminal count
    do_reset();
    hw(3'd2, 8'h30); idle(2); chk("R10 rev empty no req", {7'b0, dma_req}, 8'h00);
    ppush(8'h01); idle(1); chk("R10 rev one byte req", {7'b0, dma_req}, 8'h01);
    @(negedge clk); dma_tc = 1; @(negedge clk); dma_tc = 0;
    idle(1); chk("R10 tc drops req", {7'b0, dma_req}, 8'h00);
    hr(3'd2, rv); chk("R10 tc sets mask", rv, 8'h70);
    hw(3'd2, 8'h30); idle(2); chk("R10 re-enable req", {7'b0, dma_req}, 8'h01);
    hr(3'd3, rv); chk("R10 status dreq", rv, 8'h10);
    do_reset();
    hw(3'd2, 8'h20); idle(2); chk("R10 fwd room req", {7'b0, dma_req}, 8'h01);
    for (int i = 0; i < 16; i++) hw(3'd0, 8'(i));
    idle(2); chk("R10 fwd full no req", {7'b0, dma_req}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule